// File: doc/BRIEF.md
# Miss Hold Table for a Non-Blocking Cache Bank

This block parks core requests that missed in a non-blocking cache bank until the line they need has been filled, then feeds them back into the bank pipeline for replay. Each slot keeps a line address and an opaque payload. The payload carries the original request: write word, requester thread, request tag, read/write flag, byte enables and word-select index.

A slot can be written already marked ready, or it becomes ready when a fill for its line is taken from the fill queue. Ready slots are offered one at a time on the dequeue port, oldest first. The pipeline asserts `sched` to take the offered slot for replay. A replay that completes is retired, which frees the slot. A replay that misses again is written back with the replay flag set and returns to its own slot. A combinational probe reports whether any occupied slot holds a given line, so that the bank can force later requests to that line to miss and keep commit order.

Replays finish in the order they were scheduled. Retire strobes and replay write-backs therefore always refer to the oldest scheduled slot that is still outstanding.

Top module: `miss_hold_table`

## Requirements
- R1: After synchronous reset, every slot is empty and not ready: `full`, `deq_valid` and `probe_hit` are 0.
- R2: A new entry written with `enq_ready`=0 is not offered on the dequeue port. An entry written with `enq_ready`=1 is offered from the cycle after the write and stays offered until it is scheduled.
- R3: When `fill_valid` is high, every occupied slot whose address equals `fill_addr` becomes ready. Slots holding other addresses are unaffected.
- R4: An entry written in the same cycle as a fill to its own address is stored ready, even when `enq_ready`=0.
- R5: `probe_hit` is 1 in the same cycle exactly when some occupied slot, scheduled or not, holds `probe_addr`.
- R6: Among ready, unscheduled slots, the one written earliest is offered first.
- R7: A slot that has been scheduled is not offered again until it is written back by a replay.
- R8: `retire` frees the oldest outstanding scheduled slot. That slot then no longer counts toward `full` or `probe_hit`.
- R9: A write with `enq_replay`=1 goes into the oldest outstanding scheduled slot and takes no free slot. The entry keeps its original age for ordering, and its ready state comes from `enq_ready` or a same-cycle fill.
- R10: `full` is 1 exactly when all `ENTRIES` slots are occupied. A new (non-replay) write while `full` is high is a protocol violation.
- R11: `deq_addr` and `deq_payload` carry the address and payload stored with the offered entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enq_valid | input | 1 | Write an entry this cycle |
| enq_addr | input | ADDR_W | Line address of the written entry |
| enq_payload | input | PAY_W | Request payload of the written entry |
| enq_replay | input | 1 | Entry is a replay that missed again |
| enq_ready | input | 1 | Store the entry already ready |
| full | output | 1 | All slots occupied |
| fill_valid | input | 1 | A line fill is being taken this cycle |
| fill_addr | input | ADDR_W | Line address of that fill |
| probe_addr | input | ADDR_W | Stage-0 address to check for a hazard |
| probe_hit | output | 1 | Some occupied slot holds probe_addr |
| sched | input | 1 | Take the offered entry for replay |
| deq_valid | output | 1 | An entry is offered |
| deq_addr | output | ADDR_W | Address of the offered entry |
| deq_payload | output | PAY_W | Payload of the offered entry |
| retire | input | 1 | Oldest outstanding replay completed |

## Verification
On every cycle, the assertions check the handshake contract around the table. They flag a new write into a full table, a schedule with nothing offered, and a retire or replay write-back with no outstanding replay. They also check that an offered entry stays offered until it is taken. Age ordering, wake-up by fills on several slots at once, replays returning to their own slot with their original age, and the same-cycle fill-and-write case can only be shown by the bench's scenarios. The bench's scoreboard compares the address and payload of every replayed entry against the order that the requirements predict.

// File: rtl/miss_hold_table.sv
module miss_hold_table #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 8,
  parameter int PAY_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enq_valid,
  input  logic [ADDR_W-1:0] enq_addr,
  input  logic [PAY_W-1:0]  enq_payload,
  input  logic              enq_replay,
  input  logic              enq_ready,
  output logic              full,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [ADDR_W-1:0] probe_addr,
  output logic              probe_hit,
  input  logic              sched,
  output logic              deq_valid,
  output logic [ADDR_W-1:0] deq_addr,
  output logic [PAY_W-1:0]  deq_payload,
  input  logic              retire
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int CNT_W = $clog2(ENTRIES + 1);

  logic [ENTRIES-1:0] vld, rdy, iss;
  logic [ADDR_W-1:0]  addr_q [ENTRIES];
  logic [PAY_W-1:0]   pay_q  [ENTRIES];
  logic [ENTRIES-1:0] older  [ENTRIES];
  logic [IDX_W-1:0]   ring   [ENTRIES];
  logic [IDX_W-1:0]   rd_ptr, wr_ptr;
  logic [CNT_W-1:0]   out_cnt;

  logic [ENTRIES-1:0] cand, probe_vec;
  logic [IDX_W-1:0]   free_idx, pick_idx, tgt, head;
  logic               take, new_enq, rep_enq, pop_out, enq_fill_hit;

  assign cand         = vld & rdy & ~iss;
  assign full         = &vld;
  assign deq_valid    = |cand;
  assign probe_hit    = |probe_vec;
  assign head         = ring[rd_ptr];
  assign take         = sched && deq_valid;
  assign new_enq      = enq_valid && !enq_replay;
  assign rep_enq      = enq_valid && enq_replay;
  assign pop_out      = retire || rep_enq;
  assign tgt          = enq_replay ? head : free_idx;
  assign enq_fill_hit = fill_valid && (fill_addr == enq_addr);
  assign deq_addr     = addr_q[pick_idx];
  assign deq_payload  = pay_q[pick_idx];

  function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(ENTRIES - 1)) ? '0 : p + IDX_W'(1);
  endfunction

  always_comb begin
    free_idx = '0;
    pick_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      probe_vec[i] = vld[i] && (addr_q[i] == probe_addr);
      if (!vld[i]) free_idx = IDX_W'(i);
      if (cand[i] && !(|(cand & older_col(i)))) pick_idx = IDX_W'(i);
    end
  end

  function automatic logic [ENTRIES-1:0] older_col(input int k);
    logic [ENTRIES-1:0] c;
    for (int j = 0; j < ENTRIES; j++) c[j] = older[j][k];
    return c;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      vld     <= '0;
      rdy     <= '0;
      iss     <= '0;
      rd_ptr  <= '0;
      wr_ptr  <= '0;
      out_cnt <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        older[i] <= '0;
        ring[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++)
        if (fill_valid && vld[i] && addr_q[i] == fill_addr) rdy[i] <= 1'b1;
      if (take) begin
        iss[pick_idx] <= 1'b1;
        ring[wr_ptr]  <= pick_idx;
        wr_ptr        <= bump(wr_ptr);
      end
      if (retire) begin
        vld[head] <= 1'b0;
        rdy[head] <= 1'b0;
        iss[head] <= 1'b0;
      end
      if (pop_out) rd_ptr <= bump(rd_ptr);
      if (take && !pop_out) out_cnt <= out_cnt + CNT_W'(1);
      else if (!take && pop_out) out_cnt <= out_cnt - CNT_W'(1);
      if (enq_valid) begin
        vld[tgt]    <= 1'b1;
        iss[tgt]    <= 1'b0;
        rdy[tgt]    <= enq_ready || enq_fill_hit;
        addr_q[tgt] <= enq_addr;
        pay_q[tgt]  <= enq_payload;
      end
      if (new_enq) begin
        older[tgt] <= '0;
        for (int j = 0; j < ENTRIES; j++)
          if (j != int'(tgt)) older[j][tgt] <= vld[j];
      end
    end
  end

  AST_NO_ENQ_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
    new_enq |-> !full); // R10
  AST_REPLAY_HAS_OWNER: assert property (@(posedge clk) disable iff (rst)
    rep_enq |-> (out_cnt != '0) && !retire); // R9
  AST_RETIRE_HAS_OWNER: assert property (@(posedge clk) disable iff (rst)
    retire |-> out_cnt != '0); // R8
  AST_SCHED_NEEDS_OFFER: assert property (@(posedge clk) disable iff (rst)
    sched |-> deq_valid); // R7
  AST_OFFER_PERSISTS: assert property (@(posedge clk) disable iff (rst)
    deq_valid && !sched |=> deq_valid); // R2

endmodule

// File: tb/miss_hold_table_tb_top.sv
`timescale 1ns/1ps
module miss_hold_table_tb_top;
  localparam int AW = 8;
  localparam int PW = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic enq_valid = 0, enq_replay = 0, enq_ready = 0, fill_valid = 0, sched = 0, retire = 0;
  logic [AW-1:0] enq_addr = '0, fill_addr = '0, probe_addr = '0;
  logic [PW-1:0] enq_payload = '0;
  logic full, probe_hit, deq_valid;
  logic [AW-1:0] deq_addr;
  logic [PW-1:0] deq_payload;

  int checks = 0, fails = 0;
  logic [AW+PW-1:0] exp_q[$];
  bit done = 0;

  always #2.5 clk = ~clk;

  miss_hold_table #(.ENTRIES(4), .ADDR_W(AW), .PAY_W(PW)) dut_i (
    .clk(clk), .rst(rst), .enq_valid(enq_valid), .enq_addr(enq_addr),
    .enq_payload(enq_payload), .enq_replay(enq_replay), .enq_ready(enq_ready),
    .full(full), .fill_valid(fill_valid), .fill_addr(fill_addr),
    .probe_addr(probe_addr), .probe_hit(probe_hit), .sched(sched),
    .deq_valid(deq_valid), .deq_addr(deq_addr), .deq_payload(deq_payload),
    .retire(retire));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    enq_valid = 0; enq_replay = 0; enq_ready = 0; fill_valid = 0; sched = 0; retire = 0;
  endtask

  task automatic put(input logic [AW-1:0] a, input logic [PW-1:0] p, input bit r, input bit rep);
    enq_valid = 1; enq_addr = a; enq_payload = p; enq_ready = r; enq_replay = rep;
  endtask

  task automatic fill(input logic [AW-1:0] a);
    fill_valid = 1; fill_addr = a;
  endtask

  task automatic probe(input logic [AW-1:0] a, input bit e, input string req);
    probe_addr = a; #0.5;
    check(probe_hit == e, req, probe_hit, e);
  endtask

  task automatic replay_expect(input logic [AW-1:0] a, input logic [PW-1:0] p);
    exp_q.push_back({a, p});
    sched = 1;
    tick();
  endtask

  // scoreboard monitor: compares each scheduled entry mid-cycle
  always @(negedge clk) begin
    if (sched) begin
      if (!deq_valid || exp_q.size() == 0)
        check(0, "R7 sched without offer/expectation", deq_valid, 1);
      else begin
        logic [AW+PW-1:0] e;
        e = exp_q.pop_front();
        check({deq_addr, deq_payload} == e, "R6/R11 replay order and content",
              {deq_addr, deq_payload}, e);
      end
    end
  end

  initial begin
    #50000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    check(full == 0, "R1 full after reset", full, 0);
    check(deq_valid == 0, "R1 deq_valid after reset", deq_valid, 0);
    probe(8'h10, 0, "R1 probe after reset");

    put(8'h10, 16'h1111, 0, 0); tick();
    check(deq_valid == 0, "R2 not-ready entry hidden", deq_valid, 0);
    probe(8'h10, 1, "R5 probe hit");
    probe(8'h11, 0, "R5 probe miss");

    put(8'h20, 16'h2222, 1, 0); tick();
    check(deq_valid == 1 && deq_addr == 8'h20, "R2 ready entry offered", deq_addr, 8'h20);
    check(deq_payload == 16'h2222, "R11 payload", deq_payload, 16'h2222);
    tick();
    check(deq_valid == 1 && deq_addr == 8'h20, "R2 offer persists", deq_addr, 8'h20);

    fill(8'h10); tick();
    check(deq_addr == 8'h10, "R3 fill wakes, R6 oldest first", deq_addr, 8'h10);
    replay_expect(8'h10, 16'h1111);
    check(deq_addr == 8'h20, "R7 scheduled entry not re-offered", deq_addr, 8'h20);
    replay_expect(8'h20, 16'h2222);
    check(deq_valid == 0, "R7 nothing left to offer", deq_valid, 0);
    probe(8'h10, 1, "R5 scheduled entry still hazards");

    put(8'h10, 16'h1A1A, 0, 1); tick();
    check(deq_valid == 0, "R9 replay stored not ready", deq_valid, 0);
    retire = 1; tick();
    probe(8'h20, 0, "R8 retire frees entry");
    probe(8'h10, 1, "R9 replayed entry still held");

    put(8'h30, 16'h3333, 0, 0); tick();
    put(8'h30, 16'h4444, 0, 0); tick();
    check(full == 0, "R9 replay took no new slot", full, 0);
    put(8'h50, 16'h5555, 0, 0); tick();
    check(full == 1, "R10 full at capacity", full, 1);

    fill(8'h30); tick();
    check(deq_addr == 8'h30 && deq_payload == 16'h3333, "R3/R6 both woken, older first", deq_payload, 16'h3333);
    fill(8'h10); tick();
    check(deq_addr == 8'h10 && deq_payload == 16'h1A1A, "R9 replay keeps original age", deq_payload, 16'h1A1A);
    replay_expect(8'h10, 16'h1A1A);
    replay_expect(8'h30, 16'h3333);
    replay_expect(8'h30, 16'h4444);
    check(deq_valid == 0, "R3 unrelated entry stays asleep", deq_valid, 0);

    retire = 1; tick();
    check(full == 0, "R8 full clears on retire", full, 0);
    retire = 1; tick();
    retire = 1; tick();
    probe(8'h30, 0, "R8 retired line no longer hazards");

    put(8'h60, 16'h6666, 0, 0); fill(8'h60); tick();
    check(deq_valid == 1 && deq_addr == 8'h60, "R4 same-cycle fill makes entry ready", deq_addr, 8'h60);
    replay_expect(8'h60, 16'h6666);
    retire = 1; tick();
    fill(8'h50); tick();
    replay_expect(8'h50, 16'h5555);
    retire = 1; tick();
    check(deq_valid == 0, "R8 table drained", deq_valid, 0);
    check(full == 0, "R10 not full when empty", full, 0);
    probe(8'h50, 0, "R5 no hazard when empty");
    check(exp_q.size() == 0, "R6 all expected replays seen", exp_q.size(), 0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule